// File: doc/BRIEF.md
# Intel HEX Stream Memory Loader

This block turns an ASCII Intel HEX image, fed in one character per valid/ready handshake, into writes to a word-addressed 32-bit memory. Each record is decoded on the fly. Data bytes are packed little-endian into words. Segment base records move later data to a new window. A start-address record sets the program counter that a processor takes from reset.

It sits between a character source (a UART receiver or a boot ROM streamer) and the write port of the main memory. Once an end-of-file record arrives, the loader raises its done flag and presents the start program counter as valid. Malformed characters, truncated lines and bad checksums set one sticky error flag.

Top module: `hex_stream_loader`

## Requirements
- R1: After a synchronous active-low reset, mem_we, load_done, load_error and start_pc_valid are 0, in_ready is 1 and start_pc is 0x00010000.
- R2: A record of type 0x00 writes byte_count/4 words. Word w goes to address (load offset / 4) + w + segment word base. In each group of four data bytes, the first byte lands in bits 7:0 and the fourth in bits 31:24. mem_we is high for one cycle per word, in the cycle after the word's last hex character.
- R3: Bytes of a type 0x00 record beyond the last complete group of four cause no write.
- R4: A type 0x02 record with a 16-bit segment S, sent as its first two data bytes with the high byte first, sets the segment word base to S*4 for all later data records.
- R5: A type 0x03 record carries segment S in data bytes 0–1 and offset O in data bytes 2–3, high byte first in each. It sets start_pc to S*16+O. start_pc_valid follows load_done.
- R6: If no type 0x03 record is loaded, start_pc equals 0x00010000 when load_done rises.
- R7: A line whose first character is not ':' is skipped up to CR or LF and causes no write.
- R8: Inside a record, a character other than 0-9, A-F or a-f sets load_error, which stays set until reset. The rest of that line is discarded, and the next line that starts with ':' is parsed normally.
- R9: If the 8-bit sum of all record bytes, checksum byte included, is non-zero, load_error is set. Data words of that record are still written.
- R10: A type 0x01 record raises load_done, which then stays high. All later characters cause no write and leave start_pc unchanged.
- R11: Lower-case hex digits decode like upper-case ones, and CR and LF each end a line.
- R12: A CR or LF before a record's checksum byte is complete sets load_error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A character is offered on in_char |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Loader accepts a character (always high) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Word address of the write |
| mem_wdata | output | 32 | Word to write |
| start_pc | output | 32 | Derived start program counter |
| start_pc_valid | output | 1 | start_pc is final (load finished) |
| load_done | output | 1 | End-of-file record seen |
| load_error | output | 1 | Sticky parse or checksum error |

## Verification
The data path is tried with two records. One has a word-aligned offset and two full words. The other uses lower-case digits and CR endings and has two leftover bytes. Together they separate byte-lane order, word indexing and the dropping of partial groups. A segment record is followed by a data record, which shows whether the base is added in words rather than bytes. A deliberately bad checksum shows that the error is raised while the word is still written. Other streams check the remaining cases: a comment line, a stray letter in mid-record and a line cut short are each kept apart from a good record. A start record followed by end-of-file shows the computed PC. A bare end-of-file shows the default PC, and a record after end-of-file shows that input is ignored.

// File: rtl/hexld_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding and constants for the HEX stream loader.
// Assumes 8-bit ASCII input and 32-bit memory words.
package hexld_pkg;

    localparam int WORD_BYTES = 4;
    localparam int LANE_W     = $clog2(WORD_BYTES);
    localparam int WORD_W     = 8 * WORD_BYTES;

    localparam logic [7:0] REC_DATA  = 8'h00;
    localparam logic [7:0] REC_EOF   = 8'h01;
    localparam logic [7:0] REC_SEG   = 8'h02;
    localparam logic [7:0] REC_START = 8'h03;

    localparam logic [7:0] CH_MARK = 8'h3A;
    localparam logic [7:0] CH_CR   = 8'h0D;
    localparam logic [7:0] CH_LF   = 8'h0A;

    typedef enum logic [1:0] {
        LD_LINE = 2'd0,   // waiting for the first character of a line
        LD_REC  = 2'd1,   // inside a record, collecting hex digits
        LD_SKIP = 2'd2,   // discarding characters up to end of line
        LD_DONE = 2'd3    // end-of-file seen, all input ignored
    } ld_state_e;

endpackage

// File: rtl/hexld_char_class.sv
`timescale 1ns/1ps
// Module: combinational classifier for one ASCII character.
// Reports whether the character is a hex digit and its value, a line
// terminator or the record mark. Assumes plain 8-bit ASCII.
module hexld_char_class
    import hexld_pkg::*;
(
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib,
    output logic       is_eol,
    output logic       is_mark
);

    // Decode the digit ranges into a nibble value.
    always_comb begin
        is_hex = 1'b1;
        nib    = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            nib = 4'(ch - 8'h30);
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            nib = 4'(ch - 8'h37);
        end else if (ch >= 8'h61 && ch <= 8'h66) begin
            nib = 4'(ch - 8'h57);
        end else begin
            is_hex = 1'b0;
        end
    end

    assign is_eol  = (ch == CH_CR) || (ch == CH_LF);
    assign is_mark = (ch == CH_MARK);

endmodule

// File: rtl/hexld_word_pack.sv
`timescale 1ns/1ps
// Module: little-endian byte-lane packer.
// Stores each loaded byte in its lane. word_next shows the stored lanes
// with the byte being loaded this cycle already merged in, so the word is
// complete in the cycle its last lane arrives. Assumes that lanes of one
// word are loaded in ascending order before that word is used.
module hexld_word_pack
    import hexld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        byte_in,
    output logic [WORD_W-1:0] word_next
);

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        logic       hit;

        assign hit = load && (lane == LANE_W'(g));

        // Hold the most recent byte for this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= 8'h00;
            end else if (hit) begin
                lane_q <= byte_in;
            end
        end

        assign word_next[8*g +: 8] = hit ? byte_in : lane_q;
    end

endmodule

// File: rtl/hex_stream_loader.sv
`timescale 1ns/1ps
// Module: Intel HEX stream loader (top).
// Accepts one ASCII character per handshake and parses records of types
// 00 (data), 01 (end of file), 02 (segment base) and 03 (start address).
// Data words are written as soon as their fourth byte completes. The
// checksum only raises the error flag and never holds back a write. Lines
// that do not start with ':' are skipped. Assumes ASCII input; in_ready
// stays high and characters after end-of-file are dropped.
module hex_stream_loader
    import hexld_pkg::*;
#(
    parameter int          ADDR_W     = 20,
    parameter logic [31:0] DEFAULT_PC = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_char,
    output logic              in_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [31:0]       start_pc,
    output logic              start_pc_valid,
    output logic              load_done,
    output logic              load_error
);

    localparam int POS_W = 10;          // hex digits after ':' (max 520)
    localparam int IDX_W = POS_W - 1;   // byte index within the record

    ld_state_e         state;
    logic [POS_W-1:0]  pos;
    logic [3:0]        hi_nib;
    logic [7:0]        rec_count;
    logic [15:0]       rec_off;
    logic [7:0]        rec_type;
    logic [7:0]        sum;
    logic [31:0]       field;
    logic [ADDR_W-1:0] seg_base;

    logic              is_hex, is_eol, is_mark;
    logic [3:0]        nib;
    logic [7:0]        cur_byte, sum_next;
    logic [IDX_W-1:0]  bi, k, csum_idx;
    logic              in_rec, byte_stb, in_data, in_csum;
    logic              pack_load;
    logic [WORD_W-1:0] word_next;
    logic [15:0]       f_seg, f_off;

    hexld_char_class u_class (
        .ch      (in_char),
        .is_hex  (is_hex),
        .nib     (nib),
        .is_eol  (is_eol),
        .is_mark (is_mark)
    );

    // Byte assembly and record-position decode.
    always_comb begin
        in_rec   = in_valid && (state == LD_REC);
        byte_stb = in_rec && is_hex && pos[0];
        cur_byte = {hi_nib, nib};
        sum_next = sum + cur_byte;
        bi       = pos[POS_W-1:1];
        k        = bi - IDX_W'(4);
        csum_idx = IDX_W'(4) + IDX_W'(rec_count);
        in_data  = (bi >= IDX_W'(4)) && (bi < csum_idx);
        in_csum  = (bi == csum_idx);
        f_seg    = {field[7:0], field[15:8]};
        f_off    = {field[23:16], field[31:24]};
    end

    assign pack_load = byte_stb && in_data;

    hexld_word_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pack_load),
        .lane      (k[LANE_W-1:0]),
        .byte_in   (cur_byte),
        .word_next (word_next)
    );

    // Line state machine: record mark, skip-to-EOL and end-of-file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LD_LINE;
        end else if (in_valid) begin
            case (state)
                LD_LINE: begin
                    if (is_mark) begin
                        state <= LD_REC;
                    end else if (!is_eol) begin
                        state <= LD_SKIP;
                    end
                end
                LD_SKIP: begin
                    if (is_eol) begin
                        state <= LD_LINE;
                    end
                end
                LD_REC: begin
                    if (!is_hex) begin
                        state <= is_eol ? LD_LINE : LD_SKIP;
                    end else if (byte_stb && in_csum) begin
                        state <= (rec_type == REC_EOF) ? LD_DONE : LD_SKIP;
                    end
                end
                default: state <= LD_DONE;
            endcase
        end
    end

    // Digit position, high nibble and running checksum of the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= '0;
            hi_nib <= 4'h0;
            sum    <= 8'h00;
        end else if (in_valid && state == LD_LINE && is_mark) begin
            pos <= '0;
            sum <= 8'h00;
        end else if (in_rec && is_hex) begin
            pos <= pos + POS_W'(1);
            if (!pos[0]) begin
                hi_nib <= nib;
            end else begin
                sum <= sum_next;
            end
        end
    end

    // Header fields and the first data bytes used by address records.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_count <= 8'h00;
            rec_off   <= 16'h0000;
            rec_type  <= 8'h00;
            field     <= 32'h0;
        end else if (in_valid && state == LD_LINE && is_mark) begin
            field <= 32'h0;
        end else if (byte_stb) begin
            if (bi == IDX_W'(0)) rec_count     <= cur_byte;
            if (bi == IDX_W'(1)) rec_off[15:8] <= cur_byte;
            if (bi == IDX_W'(2)) rec_off[7:0]  <= cur_byte;
            if (bi == IDX_W'(3)) rec_type      <= cur_byte;
            if (in_data && k < IDX_W'(4)) begin
                field[{k[1:0], 3'b000} +: 8] <= cur_byte;
            end
        end
    end

    // Memory write port: one word per completed group of four data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= 32'h0;
        end else begin
            mem_we <= 1'b0;
            if (pack_load && rec_type == REC_DATA && (&k[LANE_W-1:0])) begin
                mem_we    <= 1'b1;
                mem_addr  <= seg_base + ADDR_W'(rec_off[15:LANE_W])
                           + ADDR_W'(k[IDX_W-1:LANE_W]);
                mem_wdata <= word_next;
            end
        end
    end

    // Segment base, start PC and the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_base   <= '0;
            start_pc   <= DEFAULT_PC;
            load_error <= 1'b0;
        end else if (in_rec) begin
            if (!is_hex) begin
                load_error <= 1'b1;
            end else if (byte_stb && in_csum) begin
                if (sum_next != 8'h00) begin
                    load_error <= 1'b1;
                end
                if (rec_type == REC_SEG) begin
                    seg_base <= ADDR_W'({f_seg, 2'b00});
                end
                if (rec_type == REC_START) begin
                    start_pc <= {12'h000, f_seg, 4'h0} + {16'h0000, f_off};
                end
            end
        end
    end

    assign load_done      = (state == LD_DONE);
    assign start_pc_valid = load_done;
    assign in_ready       = 1'b1;

endmodule

// File: rtl/hexld_checker.sv
`timescale 1ns/1ps
// Module: property checker for hex_stream_loader, attached by bind.
// Observes only the ports of the loader.
module hexld_checker #(
    parameter int          ADDR_W     = 20,
    parameter logic [31:0] DEFAULT_PC = 32'h0001_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       start_pc,
    input logic              load_done,
    input logic              load_error
);

    // R1: the cycle after a reset edge shows the idle state.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_we && !load_done && !load_error && start_pc == DEFAULT_PC));

    // R2: a write always follows an accepted character.
    p_write_needs_char_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(in_valid));

    // R2: a word needs at least eight characters, so writes never touch.
    p_write_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R2: the address holds between writes.
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |=> (mem_we || $stable(mem_addr)));

    // R10: done is sticky.
    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    // R10: no write once done.
    p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !mem_we);

    // R5: the start PC is frozen once done.
    p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> $stable(start_pc));

    // R8: the error flag is sticky.
    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_error |=> load_error);

endmodule

bind hex_stream_loader hexld_checker #(
    .ADDR_W     (ADDR_W),
    .DEFAULT_PC (DEFAULT_PC)
) u_hexld_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .start_pc   (start_pc),
    .load_done  (load_done),
    .load_error (load_error)
);

// File: tb/tb_hex_stream_loader.sv
`timescale 1ns/1ps
// Scoreboard bench: the record driver pushes the expected writes and the
// monitor pops them as mem_we pulses arrive.
module tb_hex_stream_loader;

    localparam int          ADDR_W = 20;
    localparam logic [31:0] DEF_PC = 32'h0001_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_char = 8'h00;
    logic              in_ready;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       start_pc;
    logic              start_pc_valid;
    logic              load_done;
    logic              load_error;

    int tests = 0;
    int fails = 0;
    int writes_seen = 0;

    logic [ADDR_W-1:0] q_addr[$];
    logic [31:0]       q_data[$];
    string             q_req[$];

    logic [7:0]        d[0:15];
    logic [ADDR_W-1:0] m_base;
    logic [31:0]       m_pc;

    always #2.5 clk = ~clk;

    hex_stream_loader #(.ADDR_W(ADDR_W), .DEFAULT_PC(DEF_PC)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_char        (in_char),
        .in_ready       (in_ready),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .start_pc       (start_pc),
        .start_pc_valid (start_pc_valid),
        .load_done      (load_done),
        .load_error     (load_error)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each write against the oldest expected one.
    always @(negedge clk) begin
        if (rst_n && mem_we === 1'b1) begin
            writes_seen++;
            tests++;
            if (q_addr.size() == 0) begin
                fails++;
                $display("FAIL unexpected write actual=%h:%h expected=none", mem_addr, mem_wdata);
            end else begin
                automatic logic [ADDR_W-1:0] ea = q_addr.pop_front();
                automatic logic [31:0] ed = q_data.pop_front();
                automatic string er = q_req.pop_front();
                if (mem_addr !== ea || mem_wdata !== ed) begin
                    fails++;
                    $display("FAIL %s actual=%h:%h expected=%h:%h", er, mem_addr, mem_wdata, ea, ed);
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    function automatic logic [7:0] hexc(input logic [3:0] n, input logic lower);
        if (n < 4'd10) return 8'h30 + 8'(n);
        return (lower ? 8'h57 : 8'h37) + 8'(n);
    endfunction

    task automatic put(input logic [7:0] c);
        @(negedge clk);
        in_char  = c;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic put_hex(input logic [7:0] b, input logic lower);
        put(hexc(b[7:4], lower));
        put(hexc(b[3:0], lower));
    endtask

    task automatic put_str(input string s);
        for (int i = 0; i < s.len(); i++) put(s[i]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n  = 1'b1;
        m_base = '0;
        m_pc   = DEF_PC;
    endtask

    // Send one record with data d[0..n-1]; model its effect on the bench side.
    task automatic send_rec(input logic [7:0] rtype, input logic [15:0] off, input int n,
                            input logic lower, input logic bad, input logic [7:0] eol,
                            input logic expect_wr, input string req);
        logic [7:0] s;
        s = 8'(n) + off[15:8] + off[7:0] + rtype;
        for (int i = 0; i < n; i++) s = s + d[i];
        if (rtype == 8'h00 && expect_wr) begin
            for (int w = 0; w < n / 4; w++) begin
                q_addr.push_back(ADDR_W'(m_base + ADDR_W'(off / 4) + ADDR_W'(w)));
                q_data.push_back({d[4*w+3], d[4*w+2], d[4*w+1], d[4*w]});
                q_req.push_back(req);
            end
        end
        if (rtype == 8'h02) m_base = ADDR_W'({d[0], d[1]} * 4);
        if (rtype == 8'h03) m_pc = {d[0], d[1]} * 16 + {16'h0, d[2], d[3]};
        put(8'h3A);
        put_hex(8'(n), lower);
        put_hex(off[15:8], lower);
        put_hex(off[7:0], lower);
        put_hex(rtype, lower);
        for (int i = 0; i < n; i++) put_hex(d[i], lower);
        put_hex(8'h00 - s + (bad ? 8'h01 : 8'h00), lower);
        put(eol);
        idle(3);
    endtask

    initial begin
        int w0;
        m_base = '0;
        m_pc   = DEF_PC;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        check("R1 mem_we", 32'(mem_we), 32'd0);
        check("R1 done", 32'(load_done), 32'd0);
        check("R1 error", 32'(load_error), 32'd0);
        check("R1 pc", start_pc, DEF_PC);
        check("R1 pc_valid", 32'(start_pc_valid), 32'd0);
        check("R1 ready", 32'(in_ready), 32'd1);

        // R7: comment line with record-like content
        w0 = writes_seen;
        put_str("#04000000AABBCCDD00\n");
        idle(3);
        check("R7 comment writes", 32'(writes_seen - w0), 32'd0);
        check("R7 comment error", 32'(load_error), 32'd0);

        // R2: two full words, LF terminator
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
        d[4] = 8'h55; d[5] = 8'h66; d[6] = 8'h77; d[7] = 8'h88;
        send_rec(8'h00, 16'h0010, 8, 1'b0, 1'b0, 8'h0A, 1'b1, "R2 data");

        // R3, R11: lower-case digits, CR end, two leftover bytes
        w0 = writes_seen;
        d[0] = 8'hA1; d[1] = 8'hB2; d[2] = 8'hC3; d[3] = 8'hD4; d[4] = 8'hE5; d[5] = 8'hF6;
        send_rec(8'h00, 16'h0100, 6, 1'b1, 1'b0, 8'h0D, 1'b1, "R11 lowercase");
        check("R3 leftover bytes give one write", 32'(writes_seen - w0), 32'd1);
        check("R11 no error", 32'(load_error), 32'd0);

        // R4: segment base then data
        d[0] = 8'h12; d[1] = 8'h34;
        send_rec(8'h02, 16'h0000, 2, 1'b0, 1'b0, 8'h0A, 1'b1, "R4 seg");
        d[0] = 8'hDE; d[1] = 8'hAD; d[2] = 8'hBE; d[3] = 8'hEF;
        send_rec(8'h00, 16'h0008, 4, 1'b0, 1'b0, 8'h0A, 1'b1, "R4 based data");
        check("R4 no error", 32'(load_error), 32'd0);

        // R9: bad checksum still writes, flags error
        d[0] = 8'h01; d[1] = 8'h02; d[2] = 8'h03; d[3] = 8'h04;
        send_rec(8'h00, 16'h0020, 4, 1'b0, 1'b1, 8'h0A, 1'b1, "R9 bad sum data");
        check("R9 error set", 32'(load_error), 32'd1);
        check("R9 queue drained", 32'(q_addr.size()), 32'd0);

        // R8: stray letter mid-record discards rest of line
        do_reset();
        idle(1);
        check("R1 error cleared", 32'(load_error), 32'd0);
        w0 = writes_seen;
        put_str(":04000000G11223344FF\n");
        idle(3);
        check("R8 error set", 32'(load_error), 32'd1);
        check("R8 no write", 32'(writes_seen - w0), 32'd0);
        d[0] = 8'hAA; d[1] = 8'hBB; d[2] = 8'hCC; d[3] = 8'hDD;
        send_rec(8'h00, 16'h0000, 4, 1'b0, 1'b0, 8'h0A, 1'b1, "R8 next line");
        check("R8 error sticky", 32'(load_error), 32'd1);

        // R12: line cut short
        do_reset();
        w0 = writes_seen;
        put_str(":0400\n");
        idle(3);
        check("R12 error set", 32'(load_error), 32'd1);
        check("R12 no write", 32'(writes_seen - w0), 32'd0);

        // R5, R10: start address then end of file
        do_reset();
        d[0] = 8'h10; d[1] = 8'h00; d[2] = 8'h02; d[3] = 8'h34;
        send_rec(8'h03, 16'h0000, 4, 1'b0, 1'b0, 8'h0A, 1'b1, "R5 start");
        check("R5 not valid before eof", 32'(start_pc_valid), 32'd0);
        send_rec(8'h01, 16'h0000, 0, 1'b0, 1'b0, 8'h0A, 1'b1, "R10 eof");
        check("R10 done", 32'(load_done), 32'd1);
        check("R5 pc valid", 32'(start_pc_valid), 32'd1);
        check("R5 pc", start_pc, m_pc);
        check("R5 pc value", start_pc, 32'h0001_0234);
        check("R5 no error", 32'(load_error), 32'd0);
        w0 = writes_seen;
        d[0] = 8'h99; d[1] = 8'h98; d[2] = 8'h97; d[3] = 8'h96;
        send_rec(8'h00, 16'h0000, 4, 1'b0, 1'b0, 8'h0A, 1'b0, "R10 ignored");
        d[0] = 8'h00; d[1] = 8'h01; d[2] = 8'h00; d[3] = 8'h00;
        send_rec(8'h03, 16'h0000, 4, 1'b0, 1'b0, 8'h0A, 1'b0, "R10 ignored start");
        check("R10 no write after done", 32'(writes_seen - w0), 32'd0);
        check("R10 pc unchanged", start_pc, 32'h0001_0234);
        check("R10 still done", 32'(load_done), 32'd1);

        // R6: end of file without a start record
        do_reset();
        send_rec(8'h01, 16'h0000, 0, 1'b0, 1'b0, 8'h0D, 1'b1, "R6 eof");
        check("R6 done", 32'(load_done), 32'd1);
        check("R6 default pc", start_pc, DEF_PC);

        check("R2 all expected writes seen", 32'(q_addr.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule